// File: doc/BRIEF.md
# Posted Store Queue with Load Bypass

This block sits between a processor core and a single-port memory. Stores from the core go into a small first-in first-out queue and are treated as done as soon as they are accepted. The core only waits on a store when the queue has no free slot. Loads arrive on a separate channel. When a load and a queued store both want the memory, the load goes first, even though the store is older.

Reordering must not give a load stale data. So each load's word address is compared, in the cycle it is presented, against every queued store. If the youngest matching store writes all four bytes, its data is returned at once and memory is not touched. If the youngest match writes only some bytes, the load waits. The queue drains up to that store, and then the load reads memory.

Two rules stop a steady stream of loads from starving the queue. After eight load services in a row while stores are waiting, one store is sent to memory. A full queue sends stores until a slot is free. Only one memory transaction is in flight at a time.

Top module: `wbuf_arb`

## Requirements
- R1: `st_ready` is low exactly when four entries are queued. An entry leaves the queue in the cycle its write is issued. So with memory stalled on one write, five back-to-back stores are accepted before `st_ready` falls.
- R2: Every accepted store is written to memory exactly once, in acceptance order, with its strobes applied (`mem_wstrb` bit b enables data bits 8b+7..8b).
- R3: When a load is waiting and stores are queued, with neither rule in R6 or R7 forcing a store, the load's memory read is issued before the next queued store.
- R4: If the youngest queued store whose word address matches has all four strobes set, the load completes with that entry's data, in the cycle it is seen with memory idle. No memory read is issued for it.
- R5: If the youngest matching entry has any strobe clear, stores are written until no match remains. The load then reads memory and returns the merged value.
- R6: After eight consecutive load services (forwarded or read) while the queue is non-empty, the next grant goes to a store.
- R7: While the queue is full and memory is idle, the next transaction is a store write, even if a load is waiting.
- R8: At most one memory transaction is outstanding. `mem_req`, `mem_we`, `mem_addr`, `mem_wdata` and `mem_wstrb` stay unchanged until `mem_ready` is seen high at a clock edge.
- R9: `ld_rsp_valid` is high only in the cycle a load completes. Read data is `mem_rdata` from the cycle `mem_ready` is high. No load completes while a write is in flight. The core holds `ld_req` and `ld_addr` until that cycle.
- R10: A synchronous active-high reset empties the queue and clears the starvation count. After reset, `st_ready` is high, and `mem_req` and `ld_rsp_valid` are low.
- R11: Address matching uses bits 31..2 only, so loads and stores to different bytes of one word match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Queue can take a store |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_strb | input | 4 | Store byte enables |
| ld_req | input | 1 | Load request, held until completion |
| ld_addr | input | 32 | Load byte address |
| ld_rsp_valid | output | 1 | Load completes this cycle |
| ld_rsp_data | output | 32 | Load data |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Transaction completes at this edge |

## Verification
The assertions check, on every cycle:
- the memory request is held steady until the memory is ready;
- a read completion always produces a load response;
- no load completes while a write is in flight;
- a full, idle queue always issues a write;
- a write starts only when the queue holds an entry;
- the count of load responses between writes stays within the starvation bound.

Only the bench's scenarios can show:
- that data values are right: forwarded words, merged partial words and the final memory image;
- that writes drain in strict first-in first-out order;
- that the starvation run actually reaches eight;
- that a load really overtakes older stores.

A strobe sweep over every byte pattern and byte offset covers the forward-or-wait decision.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int OFF_W  = $clog2(STRB_W);
    localparam int WORD_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } st_entry_t;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_RD   = 2'd1,
        ARB_WR   = 2'd2
    } arb_state_e;
endpackage

// File: rtl/wbuf_queue.sv
module wbuf_queue
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  st_entry_t         push_ent,
    input  logic              pop,
    output st_entry_t         head_ent,
    output logic              empty,
    output logic              full,
    input  logic [WORD_W-1:0] lk_word,
    output logic              lk_hit,
    output logic              lk_cover,
    output logic [DATA_W-1:0] lk_data
);
    // DEPTH must be a power of two; pointers wrap naturally
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        st_entry_t [DEPTH-1:0] ent;
        logic [PW-1:0]         head;
        logic [PW-1:0]         tail;
        logic [CW-1:0]         cnt;
    } q_state_t;

    q_state_t q_d, q_q;

    assign empty    = (q_q.cnt == '0);
    assign full     = (q_q.cnt == CW'(DEPTH));
    assign head_ent = q_q.ent[q_q.head];

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.ent[q_q.tail] = push_ent;
            q_d.tail          = q_q.tail + 1'b1;
        end
        if (pop) begin
            q_d.head = q_q.head + 1'b1;
        end
        q_d.cnt = q_q.cnt + CW'(push) - CW'(pop);
    end

    // oldest to youngest scan; the last match written is the youngest
    always_comb begin
        lk_hit   = 1'b0;
        lk_cover = 1'b0;
        lk_data  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [PW-1:0] idx;
            idx = q_q.head + PW'(i);
            if ((CW'(i) < q_q.cnt) &&
                (q_q.ent[idx].addr[ADDR_W-1:OFF_W] == lk_word)) begin
                lk_hit   = 1'b1;
                lk_cover = &q_q.ent[idx].strb;
                lk_data  = q_q.ent[idx].data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end
endmodule

// File: rtl/wbuf_sched.sv
module wbuf_sched
    import wbuf_pkg::*;
#(
    parameter int LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              lk_hit,
    input  logic              lk_cover,
    input  logic [DATA_W-1:0] lk_data,
    input  logic              q_empty,
    input  logic              q_full,
    input  st_entry_t         head_ent,
    output logic              pop,
    output logic              ld_rsp_valid,
    output logic [DATA_W-1:0] ld_rsp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [STRB_W-1:0] mem_wstrb,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        arb_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } sch_state_t;

    sch_state_t s_d, s_q;
    logic             force_wr;
    logic             grant_wr;
    logic [CNT_W-1:0] cnt_bump;

    assign force_wr = !q_empty && (q_full || (s_q.cnt >= CNT_W'(LIMIT)));
    assign cnt_bump = q_empty ? '0 :
                      ((s_q.cnt == CNT_W'(LIMIT)) ? s_q.cnt : s_q.cnt + 1'b1);

    always_comb begin
        s_d          = s_q;
        grant_wr     = 1'b0;
        pop          = 1'b0;
        ld_rsp_valid = 1'b0;
        ld_rsp_data  = '0;
        unique case (s_q.st)
            ARB_IDLE: begin
                if (force_wr || (ld_req && lk_hit && !lk_cover)) begin
                    grant_wr = 1'b1;
                end else if (ld_req && lk_hit) begin
                    ld_rsp_valid = 1'b1;
                    ld_rsp_data  = lk_data;
                    s_d.cnt      = cnt_bump;
                end else if (ld_req) begin
                    s_d.st   = ARB_RD;
                    s_d.we   = 1'b0;
                    s_d.addr = ld_addr;
                    s_d.strb = '0;
                    s_d.cnt  = cnt_bump;
                end else if (!q_empty) begin
                    grant_wr = 1'b1;
                end
            end
            ARB_RD: begin
                if (mem_ready) begin
                    ld_rsp_valid = 1'b1;
                    ld_rsp_data  = mem_rdata;
                    s_d.st       = ARB_IDLE;
                end
            end
            ARB_WR: begin
                if (mem_ready) s_d.st = ARB_IDLE;
            end
            default: s_d.st = ARB_IDLE;
        endcase
        if (grant_wr) begin
            pop      = 1'b1;
            s_d.st   = ARB_WR;
            s_d.we   = 1'b1;
            s_d.addr = head_ent.addr;
            s_d.data = head_ent.data;
            s_d.strb = head_ent.strb;
            s_d.cnt  = '0;
        end
    end

    assign mem_req   = (s_q.st != ARB_IDLE);
    assign mem_we    = s_q.we;
    assign mem_addr  = s_q.addr;
    assign mem_wdata = s_q.data;
    assign mem_wstrb = s_q.strb;

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb
    import wbuf_pkg::*;
#(
    parameter int DEPTH        = 4,
    parameter int STARVE_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [STRB_W-1:0] st_strb,
    input  logic              ld_req,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_rsp_valid,
    output logic [DATA_W-1:0] ld_rsp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [STRB_W-1:0] mem_wstrb,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    st_entry_t         push_ent;
    st_entry_t         head_ent;
    logic              q_empty;
    logic              q_full;
    logic              q_pop;
    logic              lk_hit;
    logic              lk_cover;
    logic [DATA_W-1:0] lk_data;

    assign st_ready      = !q_full;
    assign push_ent.addr = st_addr;
    assign push_ent.data = st_data;
    assign push_ent.strb = st_strb;

    wbuf_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (st_valid && st_ready),
        .push_ent (push_ent),
        .pop      (q_pop),
        .head_ent (head_ent),
        .empty    (q_empty),
        .full     (q_full),
        .lk_word  (ld_addr[ADDR_W-1:OFF_W]),
        .lk_hit   (lk_hit),
        .lk_cover (lk_cover),
        .lk_data  (lk_data)
    );

    wbuf_sched #(.LIMIT(STARVE_LIMIT)) u_sched (
        .clk          (clk),
        .rst          (rst),
        .ld_req       (ld_req),
        .ld_addr      (ld_addr),
        .lk_hit       (lk_hit),
        .lk_cover     (lk_cover),
        .lk_data      (lk_data),
        .q_empty      (q_empty),
        .q_full       (q_full),
        .head_ent     (head_ent),
        .pop          (q_pop),
        .ld_rsp_valid (ld_rsp_valid),
        .ld_rsp_data  (ld_rsp_data),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wstrb    (mem_wstrb),
        .mem_rdata    (mem_rdata),
        .mem_ready    (mem_ready)
    );
endmodule

// File: rtl/wbuf_arb_chk.sv
module wbuf_arb_chk #(
    parameter int LIMIT = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [3:0]  mem_wstrb,
    input logic        ld_rsp_valid,
    input logic        q_empty,
    input logic        q_full
);
    localparam int SW = $clog2(LIMIT + 3);
    logic [SW-1:0] rsp_run;

    always_ff @(posedge clk) begin
        if (rst)                             rsp_run <= '0;
        else if (q_empty || (mem_req && mem_we)) rsp_run <= '0;
        else if (ld_rsp_valid)               rsp_run <= rsp_run + 1'b1;
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                     && $stable(mem_wdata) && $stable(mem_wstrb)));

    // R9
    rd_done_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready) |-> ld_rsp_valid);

    // R9
    no_rsp_in_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !ld_rsp_valid);

    // R7
    full_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (q_full && !mem_req) |=> (mem_req && mem_we));

    // R2
    wr_from_queue_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req) && mem_we) |-> $past(!q_empty));

    // R6
    starve_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_run <= SW'(LIMIT + 1));
endmodule

bind wbuf_arb wbuf_arb_chk #(.LIMIT(STARVE_LIMIT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_wstrb    (mem_wstrb),
    .ld_rsp_valid (ld_rsp_valid),
    .q_empty      (q_empty),
    .q_full       (q_full)
);

// File: tb/wbuf_arb_test.sv
`timescale 1ns/1ps
module wbuf_arb_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_strb = '0;
    logic        ld_req = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        ld_rsp_valid;
    logic [31:0] ld_rsp_data;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_rdata;
    logic        mem_ready;

    always #2.5 clk = ~clk;

    wbuf_arb uut (.*);

    // memory model and transaction log
    logic [31:0] mem_arr [16];
    logic [31:0] ref_mem [16];
    bit          log_we   [512];
    logic [3:0]  log_word [512];
    int          log_n = 0;
    int          wait_c = 0;
    int          lat = 0;
    bit          stall = 1'b0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          acc_cnt = 0;
    int          total = 0;
    int          bad = 0;

    assign mem_ready = mem_req && !stall && (wait_c >= lat);
    assign mem_rdata = mem_arr[mem_addr[5:2]];

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_arr[i] = '0;
            ref_mem[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            wait_c <= 0;
            if (log_n < 512) begin
                log_we[log_n]   <= mem_we;
                log_word[log_n] <= mem_addr[5:2];
            end
            log_n <= log_n + 1;
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_wstrb[b]) mem_arr[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end else if (mem_req) begin
            wait_c <= wait_c + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_st(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_strb = s;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        for (int b = 0; b < 4; b++)
            if (s[b]) ref_mem[a[5:2]][8*b +: 8] = d[8*b +: 8];
        acc_cnt++;
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic do_load(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        ld_req = 1'b1; ld_addr = a;
        #1;
        while (!ld_rsp_valid) begin @(negedge clk); #1; end
        d = ld_rsp_data;
        @(posedge clk); #1;
        ld_req = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        while (acc_cnt != wr_cnt || mem_req) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_all();
        logic [31:0] d, e, v;
        int base, r0, pend, run, max_run;
        // R10 reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        check(st_ready == 1'b1, "R10 st_ready after reset", 32'(st_ready), 32'd1);
        check(mem_req == 1'b0, "R10 mem_req after reset", 32'(mem_req), 32'd0);
        check(ld_rsp_valid == 1'b0, "R10 ld_rsp_valid after reset", 32'(ld_rsp_valid), 32'd0);

        // R1 / R2 / R8: fill with memory stalled
        stall = 1'b1; lat = 0;
        base = log_n;
        for (int i = 0; i < 5; i++) push_st(32'(4 * (8 + i)), 32'h1000_0000 + 32'(i) * 32'h1111, 4'hF);
        @(negedge clk); #1;
        check(st_ready == 1'b0, "R1 st_ready low after five stores", 32'(st_ready), 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            check(mem_req && mem_we && mem_addr[5:2] == 4'd8, "R8 request held while stalled",
                  mem_addr, 32'd32);
        end
        stall = 1'b0;
        settle();
        for (int i = 0; i < 5; i++)
            check(log_we[base + i] && log_word[base + i] == 4'(8 + i), "R2 FIFO drain order",
                  32'(log_word[base + i]), 32'(8 + i));

        // R3 load overtakes queued stores
        stall = 1'b1;
        for (int i = 1; i < 4; i++) push_st(32'(4 * i), 32'hC0DE_0000 + 32'(i), 4'hF);
        base = log_n;
        e = ref_mem[5];
        fork
            do_load(32'd20, d);
            begin repeat (4) @(negedge clk); stall = 1'b0; end
        join
        check(log_we[base] && log_word[base] == 4'd1, "R3 in-flight write first", 32'(log_word[base]), 32'd1);
        check(!log_we[base + 1] && log_word[base + 1] == 4'd5, "R3 read before queued stores",
              32'(log_we[base + 1]), 32'd0);
        check(d == e, "R3 load data", d, e);
        #1;
        check(ld_rsp_valid == 1'b0, "R9 no response after completion", 32'(ld_rsp_valid), 32'd0);
        settle();

        // R7 full queue drains first, R6 starvation bound
        stall = 1'b1;
        for (int i = 0; i < 5; i++) push_st(32'(4 * (8 + i)), 32'h2000_0000 + 32'(i), 4'hF);
        base = log_n;
        fork
            begin
                for (int k = 0; k < 30; k++) begin
                    e = ref_mem[4 + (k % 3)];
                    do_load(32'(4 * (4 + (k % 3))), d);
                    check(d == e, "R6 load data under stream", d, e);
                end
            end
            begin repeat (3) @(negedge clk); stall = 1'b0; end
        join
        check(log_we[base] && log_we[base + 1], "R7 full queue writes before load",
              32'(log_we[base + 1]), 32'd1);
        pend = 5; run = 0; max_run = 0;
        for (int i = base; i < log_n; i++) begin
            if (log_we[i]) begin pend--; run = 0; end
            else if (pend > 0) begin run++; if (run > max_run) max_run = run; end
        end
        check(max_run == 8, "R6 longest read run with stores pending", 32'(max_run), 32'd8);
        check(pend == 0, "R6 stores drained during load stream", 32'(pend), 32'd0);
        settle();

        // R4 / R5 / R11 strobe and byte-offset sweep
        lat = 2;
        for (int w = 1; w < 4; w++) begin
            for (int s = 0; s < 16; s++) begin
                v = 32'h5A00_0000 + 32'(w) * 32'h0001_0000 + 32'(s) * 32'h0000_0101;
                push_st(32'd60, ~v, 4'hF);
                push_st(32'(4 * w + ((s + 1) % 4)), v, 4'(s));
                e = ref_mem[w];
                r0 = rd_cnt;
                do_load(32'(4 * w + (s % 4)), d);
                if (s == 15) begin
                    check(d == e, "R4 R11 forwarded data", d, e);
                    check(rd_cnt == r0, "R4 no memory read on full hit", 32'(rd_cnt - r0), 32'd0);
                end else begin
                    check(d == e, "R5 R11 merged data after drain", d, e);
                    check(rd_cnt == r0 + 1, "R5 one memory read on partial hit", 32'(rd_cnt - r0), 32'd1);
                end
                settle();
            end
        end

        // R4 youngest of several full matches
        push_st(32'd60, 32'h1, 4'hF);
        push_st(32'd8, 32'hAAAA_0001, 4'hF);
        push_st(32'd8, 32'hBBBB_0002, 4'hF);
        r0 = rd_cnt;
        do_load(32'd8, d);
        check(d == 32'hBBBB_0002, "R4 youngest entry forwarded", d, 32'hBBBB_0002);
        check(rd_cnt == r0, "R4 youngest forward needs no read", 32'(rd_cnt - r0), 32'd0);
        settle();

        // R5 youngest partial behind older full
        push_st(32'd60, 32'h2, 4'hF);
        push_st(32'd12, 32'h1234_5678, 4'hF);
        push_st(32'd13, 32'hFFFF_FF00, 4'h2);
        e = ref_mem[3];
        do_load(32'd12, d);
        check(d == e, "R5 youngest partial merged", d, e);
        settle();

        // R2 final memory image
        for (int w = 0; w < 16; w++)
            check(mem_arr[w] == ref_mem[w], "R2 final memory image", mem_arr[w], ref_mem[w]);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog R1..all actual=expired expected=finished");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule